// File: doc/BRIEF.md
# Staircase Gate Generator for a Nineteen-Level Inverter

The block drives the twelve switches of a single-phase inverter whose three DC sources stand in a 1:2:6 ratio. From those sources it can build a stepped output with nineteen levels, from −9 to +9 units. A 32-bit phase accumulator advances a sine reference by a programmable increment on every enabled clock. The sine is read from a quarter-wave table that is computed inside the code and unfolded by the two top phase bits. The sample is scaled by nine and by a modulation index. It is then rounded to the nearest whole level. No carrier is used, so the switches move only at the fundamental rate, for example 50 Hz.

A fixed pattern table turns the signed level into a 12-bit gate word. While the block is enabled the gate word changes only when the level changes. A one-cycle strobe marks each new word. With the enable low, or during reset, every switch is off and the reported level is zero.

A small controller sequences the outputs through three states. `ST_OFF` is entered on reset or when enable is low. `ST_FILL` lasts one cycle: the first sine sample is taken there and the first gate word is loaded on leaving it. `ST_RUN` follows while enable stays high. The transitions are: OFF→FILL when enable is high, FILL→RUN when enable is high, RUN→RUN when enable is high, and any state→OFF when enable is low.

Top module: `staircase_gate_gen`

## Requirements
- R1: While `rst` is high, and after any clock edge at which `en` was low, `gate_o` is all zeros, `level_o` is 0 and `step_o` is 0. The phase restarts from 0.
- R2: Count the enabled edges from j = 0 onward. After edge 0 the outputs are still all off. After edge j ≥ 1 the outputs reflect the reference at phase (j−1)·`phase_step` mod 2^32, using the `mod_index` value present at edge j.
- R3: The sine sample for phase p is built as follows. Let q = p[31:30] and k = p[29:24]. Use index 63−k when q[0] is 1. The entry e(i) = round(sin((i+0.5)·π/128)·32768), with halves rounded up. The sample is −e when q[1] is 1, and +e otherwise.
- R4: With Mc = min(`mod_index`, 256), `level_o` = sign(s)·floor((9·Mc·|s| + 2^22) / 2^23). This rounds ties away from zero and always lies in −9..+9.
- R5: Any `mod_index` above 256 (1.0 in Q1.8) behaves exactly like 256.
- R6: Gate bit 11 is switch S1 and bit 0 is S12, and 1 means the switch is on. For levels ≥ 0, S1=1, S2=0, S11=0 and S12=1. For negative levels these four bits are inverted.
- R7: The magnitude m is written as a+2b+6c, with c = (m ≥ 4), a ∈ {0,1} and b ∈ {−1,0,+1}. S3=a and S8=¬a. S6=c and S10=¬c. S4,S5,S7,S9 are 1,0,1,0 for b=+1, 0,1,0,0 for b=−1, and 0,0,0,1 for b=0. Example words: +9→101101100001, +1→101000001101, 0→100000011101, −9→011101100010.
- R8: `step_o` is high for exactly the cycle after an enabled edge at which `gate_o` took a different value. The first loaded word always counts as a change. Otherwise `gate_o` holds.
- R9: Over one full period, `mod_index` 256 gives all 19 levels, 205 gives 15 (peak ±7) and 154 gives 11 (peak ±5).
- R10: The level at phase p+2^31 is the negative of the level at phase p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low forces all switches off |
| phase_step | input | 32 | Phase increment per enabled clock |
| mod_index | input | 9 | Modulation index, unsigned Q1.8 |
| gate_o | output | 12 | Switch commands, S1 at bit 11 to S12 at bit 0 |
| level_o | output | 5 | Current output level, signed, −9..+9 |
| step_o | output | 1 | One-cycle strobe on each new gate word |

## Verification
The assertions assume that `rst` and `en` are synchronous to `clk` and that `rst` is held for at least one edge before it is released. They place no limit on `phase_step` or `mod_index`, because the rounding bounds the level for any index. The bench drives every input on the falling edge, so each rising edge sees settled values. It keeps `mod_index` constant within each full-period sweep, so the level histogram and the half-period mirror relation are both well defined. Other stretches of the stimulus vary the increment, drop enable mid-run, assert reset while running and drive index values far above 1.0.

// File: rtl/stair_pkg.sv
package stair_pkg;

    localparam int N_POS  = 9;
    localparam int GATE_W = 12;
    localparam int LMAG_W = $clog2(N_POS + 1);
    localparam int LVL_W  = LMAG_W + 1;
    localparam int N_LVL  = 2 * N_POS + 1;
    localparam real STAIR_PI = 3.141592653589793;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_FILL = 2'd1,
        ST_RUN  = 2'd2
    } stair_state_t;

    // Quarter-wave entry, sampled at the middle of each bin so that unfolding mirrors exactly.
    function automatic int quarter_entry(input int k, input int aw, input int fw);
        real ang;
        ang = (real'(k) + 0.5) * STAIR_PI / (2.0 * real'(2 ** aw));
        return $rtoi($sin(ang) * (2.0 ** fw) + 0.5);
    endfunction

    // Switch pattern for a signed level; the word is S1 (msb) .. S12 (lsb).
    function automatic logic [GATE_W-1:0] gate_pattern(input int lvl);
        int          mag;
        int          rem;
        logic        neg;
        logic        src_lo;
        logic        src_hi;
        logic [3:0]  mid_bits;
        logic [GATE_W-1:0] w;
        neg    = (lvl < 0);
        mag    = neg ? -lvl : lvl;
        src_hi = (mag >= 4);
        rem    = mag - (src_hi ? 6 : 0);
        src_lo = (rem == -1) || (rem == 1) || (rem == 3);
        // mid_bits = {S4, S5, S7, S9}
        if (rem >= 2)       mid_bits = 4'b1010;
        else if (rem < 0)   mid_bits = 4'b0100;
        else                mid_bits = 4'b0001;
        w[11] = ~neg;          // S1
        w[10] =  neg;          // S2
        w[9]  =  src_lo;       // S3
        w[8]  =  mid_bits[3];  // S4
        w[7]  =  mid_bits[2];  // S5
        w[6]  =  src_hi;       // S6
        w[5]  =  mid_bits[1];  // S7
        w[4]  = ~src_lo;       // S8
        w[3]  =  mid_bits[0];  // S9
        w[2]  = ~src_hi;       // S10
        w[1]  =  neg;          // S11
        w[0]  = ~neg;          // S12
        return w;
    endfunction

endpackage

// File: rtl/stair_phase_sine.sv
module stair_phase_sine #(
    parameter int PHASE_W  = 32,
    parameter int LUT_AW   = 6,
    parameter int AMP_FRAC = 15
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run,
    input  logic [PHASE_W-1:0]    step_in,
    output logic signed [AMP_FRAC:0] sample_o
);

    localparam int DEPTH = 1 << LUT_AW;

    logic [PHASE_W-1:0]  acc;
    logic [1:0]          quad;
    logic [LUT_AW-1:0]   idx;
    logic [LUT_AW-1:0]   addr;
    logic [AMP_FRAC-1:0] lut [DEPTH];
    logic signed [AMP_FRAC:0] mag_s;
    logic signed [AMP_FRAC:0] samp_nxt;

    for (genvar g = 0; g < DEPTH; g++) begin : g_lut
        assign lut[g] = AMP_FRAC'(stair_pkg::quarter_entry(g, LUT_AW, AMP_FRAC));
    end

    assign quad  = acc[PHASE_W-1 -: 2];
    assign idx   = acc[PHASE_W-3 -: LUT_AW];
    assign addr  = quad[0] ? ~idx : idx;
    assign mag_s = $signed({1'b0, lut[addr]});

    always_comb begin
        if (quad[1]) samp_nxt = -mag_s;
        else         samp_nxt =  mag_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc      <= '0;
            sample_o <= '0;
        end else begin
            acc      <= acc + step_in;
            sample_o <= samp_nxt;
        end
    end

endmodule

// File: rtl/stair_level_round.sv
module stair_level_round #(
    parameter int AMP_FRAC = 15,
    parameter int MI_W     = 9,
    parameter int MI_FRAC  = 8
) (
    input  logic signed [AMP_FRAC:0]           sample,
    input  logic [MI_W-1:0]                    mod_index,
    output logic signed [stair_pkg::LVL_W-1:0] level
);

    localparam int MI_ONE = 1 << MI_FRAC;
    localparam int SHIFT  = AMP_FRAC + MI_FRAC;
    localparam int PROD_W = stair_pkg::LMAG_W + MI_W + AMP_FRAC;
    localparam int LMAG_W = stair_pkg::LMAG_W;

    logic [MI_W-1:0]     mc;
    logic [AMP_FRAC-1:0] smag;
    logic [PROD_W-1:0]   prod;
    logic [PROD_W-1:0]   rsum;
    logic [LMAG_W-1:0]   lmag;
    logic signed [LMAG_W:0] lmag_s;

    assign mc     = (mod_index > MI_W'(MI_ONE)) ? MI_W'(MI_ONE) : mod_index;
    assign smag   = sample[AMP_FRAC] ? AMP_FRAC'(-sample) : AMP_FRAC'(sample);
    assign prod   = PROD_W'(stair_pkg::N_POS) * PROD_W'(mc) * PROD_W'(smag);
    assign rsum   = prod + (PROD_W'(1) << (SHIFT - 1));
    assign lmag   = LMAG_W'(rsum >> SHIFT);
    assign lmag_s = $signed({1'b0, lmag});

    always_comb begin
        if (sample[AMP_FRAC]) level = -lmag_s;
        else                  level =  lmag_s;
    end

endmodule

// File: rtl/stair_gate_rom.sv
module stair_gate_rom (
    input  logic signed [stair_pkg::LVL_W-1:0] level,
    output logic [stair_pkg::GATE_W-1:0]       gate
);

    localparam int LVL_W  = stair_pkg::LVL_W;
    localparam int ROM_N  = 1 << LVL_W;

    logic [stair_pkg::GATE_W-1:0] rom [ROM_N];
    logic [LVL_W-1:0]             slot;

    for (genvar g = 0; g < ROM_N; g++) begin : g_rom
        if (g < stair_pkg::N_LVL) begin : g_used
            assign rom[g] = stair_pkg::gate_pattern(g - stair_pkg::N_POS);
        end else begin : g_spare
            assign rom[g] = '0;
        end
    end

    assign slot = LVL_W'(level) + LVL_W'(stair_pkg::N_POS);
    assign gate = rom[slot];

endmodule

// File: rtl/staircase_gate_gen.sv
module staircase_gate_gen #(
    parameter int PHASE_W  = 32,
    parameter int LUT_AW   = 6,
    parameter int AMP_FRAC = 15,
    parameter int MI_W     = 9,
    parameter int MI_FRAC  = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  en,
    input  logic [PHASE_W-1:0]                    phase_step,
    input  logic [MI_W-1:0]                       mod_index,
    output logic [stair_pkg::GATE_W-1:0]          gate_o,
    output logic signed [stair_pkg::LVL_W-1:0]    level_o,
    output logic                                  step_o
);

    import stair_pkg::*;

    stair_state_t state, state_nxt;

    logic signed [AMP_FRAC:0]  sample;
    logic signed [LVL_W-1:0]   lvl_nxt;
    logic [GATE_W-1:0]         gate_nxt;

    stair_phase_sine #(
        .PHASE_W  (PHASE_W),
        .LUT_AW   (LUT_AW),
        .AMP_FRAC (AMP_FRAC)
    ) u_phase (
        .clk      (clk),
        .rst      (rst),
        .run      (en),
        .step_in  (phase_step),
        .sample_o (sample)
    );

    stair_level_round #(
        .AMP_FRAC  (AMP_FRAC),
        .MI_W      (MI_W),
        .MI_FRAC   (MI_FRAC)
    ) u_round (
        .sample    (sample),
        .mod_index (mod_index),
        .level     (lvl_nxt)
    );

    stair_gate_rom u_rom (
        .level (lvl_nxt),
        .gate  (gate_nxt)
    );

    always_comb begin
        state_nxt = ST_OFF;
        unique case (state)
            ST_OFF:  state_nxt = en ? ST_FILL : ST_OFF;
            ST_FILL: state_nxt = en ? ST_RUN  : ST_OFF;
            ST_RUN:  state_nxt = en ? ST_RUN  : ST_OFF;
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OFF;
        else     state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gate_o  <= '0;
            level_o <= '0;
            step_o  <= 1'b0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    gate_o  <= '0;
                    level_o <= '0;
                    step_o  <= 1'b0;
                end
                ST_FILL, ST_RUN: begin
                    gate_o  <= gate_nxt;
                    level_o <= lvl_nxt;
                    step_o  <= (gate_nxt != gate_o);
                end
                default: begin
                    gate_o  <= '0;
                    level_o <= '0;
                    step_o  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/staircase_gate_chk.sv
module staircase_gate_chk (
    input logic                                 clk,
    input logic                                 rst,
    input logic                                 en,
    input logic [stair_pkg::GATE_W-1:0]         gate,
    input logic signed [stair_pkg::LVL_W-1:0]   level,
    input logic                                 step
);

    // R1: a disabled edge leaves every switch off
    a_r1_idle_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == '0 && level == 0 && !step));

    // R1: an all-off word only ever reports level zero
    a_r1_dark_is_zero: assert property (@(posedge clk) disable iff (rst)
        (gate == '0) |-> (level == 0));

    // R4: reported level stays inside the nineteen-level span
    a_r4_level_span: assert property (@(posedge clk) disable iff (rst)
        (level >= -9) && (level <= 9));

    // R6: polarity switches are complementary and follow the level sign
    a_r6_polarity: assert property (@(posedge clk) disable iff (rst)
        (gate != '0) |-> ((gate[11] != gate[10]) && (gate[11] == gate[0])
                          && (gate[10] == gate[1]) && (gate[11] == (level >= 0))));

    // R8: a strobe marks a real change of the word
    a_r8_step_means_change: assert property (@(posedge clk) disable iff (rst)
        step |-> (gate != $past(gate)));

    // R8: without a strobe an enabled edge holds the word
    a_r8_quiet_means_hold: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && !$past(rst) && !step) |-> $stable(gate));

    // R2: strobes only come from enabled edges
    a_r2_step_needs_enable: assert property (@(posedge clk) disable iff (rst)
        step |-> $past(en));

endmodule

bind staircase_gate_gen staircase_gate_chk i_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .gate  (gate_o),
    .level (level_o),
    .step  (step_o)
);

// File: tb/test_staircase_gate_gen.sv
module test_staircase_gate_gen;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [31:0]        phase_step = '0;
    logic [8:0]         mod_index  = '0;
    logic [11:0]        gate_o;
    logic signed [4:0]  level_o;
    logic               step_o;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        int          lvl;
        logic [11:0] gate;
        bit          step;
        int          slot;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    int   obs [256];

    logic [31:0] m_ph   = '0;
    int          m_nen  = 0;
    int          m_pend = 0;
    logic [11:0] m_prev = '0;

    always #4 clk = ~clk;

    staircase_gate_gen i_staircase_gate_gen (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .phase_step (phase_step),
        .mod_index  (mod_index),
        .gate_o     (gate_o),
        .level_o    (level_o),
        .step_o     (step_o)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // R3 sample model
    function automatic int b_sine(input logic [31:0] ph);
        int  k;
        int  e;
        real ang;
        k = int'(ph[29:24]);
        if (ph[30]) k = 63 - k;
        ang = (real'(k) + 0.5) * 3.141592653589793 / 128.0;
        e = $rtoi($sin(ang) * 32768.0 + 0.5);
        return ph[31] ? -e : e;
    endfunction

    // R4 / R5 rounding model
    function automatic int b_level(input int s, input int m);
        int mc;
        int a;
        int mag;
        mc  = (m > 256) ? 256 : m;
        a   = (s < 0) ? -s : s;
        mag = (9 * mc * a + 4194304) / 8388608;
        return (s < 0) ? -mag : mag;
    endfunction

    // R6 / R7 pattern model
    function automatic logic [11:0] b_gate(input int lvl);
        int  mag;
        int  r;
        bit  a;
        int  b;
        bit  c;
        bit  ng;
        logic [11:0] w;
        ng  = (lvl < 0);
        mag = ng ? -lvl : lvl;
        c   = (mag >= 4);
        r   = mag - (c ? 6 : 0);
        a   = (r == -1 || r == 1 || r == 3);
        b   = (r >= 2) ? 1 : ((r < 0) ? -1 : 0);
        w = '0;
        w[11] = !ng; w[10] = ng; w[1] = ng; w[0] = !ng;
        w[9]  = a;   w[4]  = !a;
        w[6]  = c;   w[2]  = !c;
        if (b == 1)       begin w[8] = 1; w[5] = 1; end
        else if (b == -1) begin w[7] = 1; end
        else              begin w[3] = 1; end
        return w;
    endfunction

    task automatic cycle(input bit r, input bit e, input logic [31:0] inc,
                         input logic [8:0] m, input int slot, input string tag);
        exp_t it;
        @(negedge clk);
        rst = r; en = e; phase_step = inc; mod_index = m;
        it.slot = slot;
        it.tag  = tag;
        if (r || !e) begin
            it.lvl = 0; it.gate = '0; it.step = 0;
            m_ph = '0; m_nen = 0; m_prev = '0; m_pend = 0;
        end else if (m_nen == 0) begin
            it.lvl = 0; it.gate = '0; it.step = 0;
            m_pend = b_sine(m_ph);
            m_ph   = m_ph + inc;
            m_nen  = 1;
        end else begin
            it.lvl  = b_level(m_pend, int'(m));
            it.gate = b_gate(it.lvl);
            it.step = (it.gate != m_prev);
            m_prev  = it.gate;
            m_pend  = b_sine(m_ph);
            m_ph    = m_ph + inc;
        end
        sb_q.push_back(it);
    endtask

    task automatic drain();
        @(posedge clk);
        #3;
    endtask

    // R9 / R10: one full period at 256 samples, then histogram and mirror checks
    task automatic sweep(input logic [8:0] m, input int want_n, input int want_pk, input string tag);
        int seen [19];
        int cnt;
        int pk;
        int bad;
        cycle(0, 0, 32'h0100_0000, m, -1, "R1");
        cycle(0, 1, 32'h0100_0000, m, -1, tag);
        for (int j = 1; j <= 256; j++) cycle(0, 1, 32'h0100_0000, m, j - 1, tag);
        drain();
        for (int i = 0; i < 19; i++) seen[i] = 0;
        pk = 0;
        for (int i = 0; i < 256; i++) begin
            if (obs[i] >= -9 && obs[i] <= 9) seen[obs[i] + 9] = 1;
            if (obs[i] > pk) pk = obs[i];
        end
        cnt = 0;
        for (int i = 0; i < 19; i++) cnt += seen[i];
        chk(cnt == want_n, "R9", "distinct levels per period", cnt, want_n);
        chk(pk == want_pk, "R9", "positive peak level", pk, want_pk);
        bad = 0;
        for (int i = 0; i < 128; i++) if (obs[i + 128] != -obs[i]) bad++;
        chk(bad == 0, "R10", "half-period mirror mismatches", bad, 0);
    endtask

    // Scoreboard monitor, sampling after the edge has settled
    initial begin
        exp_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                chk(int'(level_o) == it.lvl, it.tag, "level", int'(level_o), it.lvl);
                chk(gate_o == it.gate, it.tag, "gate word", int'(gate_o), int'(it.gate));
                chk(step_o == it.step, "R8", "step strobe", int'(step_o), int'(it.step));
                if (it.slot >= 0) obs[it.slot] = int'(level_o);
                if (gate_o != '0) begin
                    if (level_o == 9)
                        chk(gate_o == 12'b101101100001, "R7", "word for +9", int'(gate_o), 12'b101101100001);
                    if (level_o == -9)
                        chk(gate_o == 12'b011101100010, "R7", "word for -9", int'(gate_o), 12'b011101100010);
                    if (level_o == 1)
                        chk(gate_o == 12'b101000001101, "R7", "word for +1", int'(gate_o), 12'b101000001101);
                    if (level_o == 0)
                        chk(gate_o == 12'b100000011101, "R6", "word for 0", int'(gate_o), 12'b100000011101);
                end
            end
        end
    end

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) cycle(1, 0, '0, '0, -1, "R1");
        for (int i = 0; i < 2; i++) cycle(0, 0, 32'h0100_0000, 9'd256, -1, "R1");

        // R3 / R4 / R9 / R10: full scale, 0.8 and 0.6
        sweep(9'd256, 19, 9, "R3");
        sweep(9'd205, 15, 7, "R4");
        sweep(9'd154, 11, 5, "R4");

        // R5: index far above one behaves as one
        sweep(9'd511, 19, 9, "R5");

        // R2: irregular increment with phase wrap
        cycle(0, 0, 32'h0123_4567, 9'd180, -1, "R1");
        for (int j = 0; j < 300; j++) cycle(0, 1, 32'h0123_4567, 9'd180, -1, "R2");

        // R1: enable dropped mid-run, then resumed
        for (int j = 0; j < 3; j++) cycle(0, 0, 32'h0123_4567, 9'd180, -1, "R1");
        for (int j = 0; j < 120; j++) cycle(0, 1, 32'h0271_0000, 9'd230, -1, "R2");

        // R1: reset while running
        for (int j = 0; j < 2; j++) cycle(1, 1, 32'h0271_0000, 9'd230, -1, "R1");
        for (int j = 0; j < 80; j++) cycle(0, 1, 32'h0271_0000, 9'd230, -1, "R2");

        // R8: zero index holds the zero-level word after one strobe
        cycle(0, 0, 32'h0100_0000, 9'd0, -1, "R1");
        for (int j = 0; j < 60; j++) cycle(0, 1, 32'h0100_0000, 9'd0, -1, "R8");

        // R4: index changed during a run
        for (int j = 0; j < 200; j++)
            cycle(0, 1, 32'h0080_0000, (j < 100) ? 9'd256 : 9'd100, -1, "R4");

        cycle(0, 0, '0, '0, -1, "R1");
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule